// File: doc/BRIEF.md
# Multi-Writer Register Reservation Tracker

This block sits beside a shared register file in a processor that issues a block of four instructions per cycle. For every architectural register it keeps a bitmap with one bit per in-flight instruction that still has to write that register. A bit position stands for a producer and is built from the block's slot number (0 to 3, used circularly by the issue logic) and the lane (0 to 3) within the block. The bit index is `slot*4 + lane`, so each bitmap is 16 bits wide.

When a block issues, every lane presents one destination register and two source registers. Each source gets back the bitmap of all older pending writers of its register. Older writers include earlier lanes of the same block. Each enabled destination then sets its own bit in its register's entry. A producer's bit is removed from every entry when that producer commits on its lane's result bus, when its block slot retires, or when it is squashed. There is no tag comparison: the position of the bit is the identity of the producer.

The source bitmaps are combinational in the issue cycle. Table updates take effect at the next clock edge. Clears that arrive in the issue cycle already apply to that cycle's source bitmaps.

Top module: `resv_tracker`

## Requirements
- R1: After reset every entry is empty, so every source bitmap of a block that reads any register is zero.
- R2: An issued lane with its destination enabled sets bit `slot*4+lane` in the entry of its destination register. Later blocks that read that register see the bit until it is cleared.
- R3: A source bitmap includes the bit `issueSlot*4+j` for every lower lane j of the same block whose enabled destination equals that source register. It never gains a same-block bit from its own lane or from a higher lane.
- R4: A commit on lane bus c with slot s clears bit `s*4+c` from every entry. The clear already applies to source bitmaps produced in the same cycle.
- R5: A retire of slot s clears bits `s*4` through `s*4+3` from every entry. The clear also applies to same-cycle source bitmaps.
- R6: Every bit set in the squash mask is cleared from every entry in the same cycle, and is absent from same-cycle source bitmaps.
- R7: An entry accumulates the bits of all pending writers across up to four blocks. A lane-3 source can therefore see 15 producers at once.
- R8: When a bit is set by an issuing destination and cleared by a commit, retire or squash in the same cycle, the set wins.
- R9: While issue-valid is low, all source bitmaps are zero and no entry gains a bit.
- R10: A lane whose destination-enable is low reserves nothing, even though it presents a destination identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | A block of four instructions issues this cycle |
| issueSlot | input | 2 | Block slot of the issuing block |
| dstValid | input | 4 | Per-lane destination enable |
| dstReg | input | 20 | Per-lane destination register, lane n at bits [5n+4:5n] |
| srcAReg | input | 20 | Per-lane first source register |
| srcBReg | input | 20 | Per-lane second source register |
| commitValid | input | 4 | Per-lane result bus carries a committed result |
| commitSlot | input | 8 | Per-lane slot of the committing producer, lane n at bits [2n+1:2n] |
| retireValid | input | 1 | A block slot retires |
| retireSlot | input | 2 | Slot that retires |
| squashMask | input | 16 | Producer bit positions to squash |
| srcAMap | output | 64 | Per-lane first-source writer bitmap, lane n at bits [16n+15:16n] |
| srcBMap | output | 64 | Per-lane second-source writer bitmap |

## Verification
Random blocks draw registers from a pool of eight, so that many sources meet many writers. This separates a correct merge of table bits and same-block bits from one that drops either part. Random commits, retires and squash masks that overlap the issue cycle test whether clears reach the same-cycle bitmaps and whether set beats clear. Directed blocks cover the points that random stimulus reaches rarely: one register written by every lane of four blocks (15 producers), own-lane and higher-lane exclusion, disabled destinations, and idle cycles that still carry destinations.

// File: rtl/resv_pkg.sv
package resv_pkg;
  localparam int LANES    = 4;
  localparam int SLOTS    = 4;
  localparam int NUM_REGS = 32;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int MAP_W    = LANES * SLOTS;

  typedef logic [MAP_W-1:0] resv_map_t;

  // Strobes from control to the table datapath.
  typedef struct packed {
    resv_map_t               clearMask;
    logic [LANES-1:0]        writeEn;
    logic [SLOT_W-1:0]       slot;
    logic                    readEn;
  } resv_strobe_t;

  function automatic resv_map_t slotLaneBit(input logic [SLOT_W-1:0] slot, input int lane);
    return resv_map_t'(1) << (int'(slot) * LANES + lane);
  endfunction

  function automatic resv_map_t slotBits(input logic [SLOT_W-1:0] slot);
    resv_map_t laneOnes;
    laneOnes = resv_map_t'((1 << LANES) - 1);
    return laneOnes << (int'(slot) * LANES);
  endfunction
endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic                      issueValid,
  input  logic [SLOT_W-1:0]         issueSlot,
  input  logic [LANES-1:0]          dstValid,
  input  logic [LANES-1:0]          commitValid,
  input  logic [LANES*SLOT_W-1:0]   commitSlot,
  input  logic                      retireValid,
  input  logic [SLOT_W-1:0]         retireSlot,
  input  resv_map_t                 squashMask,
  output resv_strobe_t              strobe
);
  resv_map_t commitClear;
  resv_map_t retireClear;

  // Each lane bus owns one bit column; its slot picks the row.
  always_comb begin
    commitClear = '0;
    for (int c = 0; c < LANES; c++) begin
      if (commitValid[c])
        commitClear |= slotLaneBit(commitSlot[c*SLOT_W +: SLOT_W], c);
    end
  end

  assign retireClear = retireValid ? slotBits(retireSlot) : '0;

  always_comb begin
    strobe.clearMask = commitClear | retireClear | squashMask;
    strobe.writeEn   = issueValid ? dstValid : '0;
    strobe.slot      = issueSlot;
    strobe.readEn    = issueValid;
  end
endmodule

// File: rtl/resv_read_port.sv
module resv_read_port
  import resv_pkg::*;
#(
  parameter int LANE = 0
) (
  input  resv_strobe_t             strobe,
  input  resv_map_t                lookedUp,
  input  logic [REG_W-1:0]         srcReg,
  input  logic [LANES*REG_W-1:0]   dstReg,
  output resv_map_t                depMap
);
  resv_map_t intraMap;

  // Only lanes strictly below this one count as older in the block.
  always_comb begin
    intraMap = '0;
    for (int j = 0; j < LANE; j++) begin
      if (strobe.writeEn[j] && dstReg[j*REG_W +: REG_W] == srcReg)
        intraMap |= slotLaneBit(strobe.slot, j);
    end
  end

  assign depMap = strobe.readEn ? (lookedUp | intraMap) : '0;
endmodule

// File: rtl/resv_table.sv
module resv_table
  import resv_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  resv_strobe_t             strobe,
  input  logic [LANES*REG_W-1:0]   dstReg,
  input  logic [LANES*REG_W-1:0]   srcAReg,
  input  logic [LANES*REG_W-1:0]   srcBReg,
  output logic [LANES*MAP_W-1:0]   srcAMap,
  output logic [LANES*MAP_W-1:0]   srcBMap
);
  resv_map_t entry   [NUM_REGS];
  resv_map_t liveMap [NUM_REGS];
  resv_map_t setMap  [NUM_REGS];

  // Entries with this cycle's clears already applied.
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++)
      liveMap[r] = entry[r] & ~strobe.clearMask;
  end

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      setMap[r] = '0;
      for (int j = 0; j < LANES; j++) begin
        if (strobe.writeEn[j] && dstReg[j*REG_W +: REG_W] == REG_W'(r))
          setMap[r] |= slotLaneBit(strobe.slot, j);
      end
    end
  end

  // A set is applied after the clear, so a new reservation wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) entry[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) entry[r] <= liveMap[r] | setMap[r];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    resv_map_t lookA;
    resv_map_t lookB;
    resv_map_t mapA;
    resv_map_t mapB;

    assign lookA = liveMap[srcAReg[l*REG_W +: REG_W]];
    assign lookB = liveMap[srcBReg[l*REG_W +: REG_W]];

    resv_read_port #(.LANE(l)) u_portA (
      .strobe(strobe), .lookedUp(lookA),
      .srcReg(srcAReg[l*REG_W +: REG_W]), .dstReg(dstReg), .depMap(mapA)
    );
    resv_read_port #(.LANE(l)) u_portB (
      .strobe(strobe), .lookedUp(lookB),
      .srcReg(srcBReg[l*REG_W +: REG_W]), .dstReg(dstReg), .depMap(mapB)
    );

    assign srcAMap[l*MAP_W +: MAP_W] = mapA;
    assign srcBMap[l*MAP_W +: MAP_W] = mapB;
  end
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker
  import resv_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issueValid,
  input  logic [SLOT_W-1:0]         issueSlot,
  input  logic [LANES-1:0]          dstValid,
  input  logic [LANES*REG_W-1:0]    dstReg,
  input  logic [LANES*REG_W-1:0]    srcAReg,
  input  logic [LANES*REG_W-1:0]    srcBReg,
  input  logic [LANES-1:0]          commitValid,
  input  logic [LANES*SLOT_W-1:0]   commitSlot,
  input  logic                      retireValid,
  input  logic [SLOT_W-1:0]         retireSlot,
  input  logic [MAP_W-1:0]          squashMask,
  output logic [LANES*MAP_W-1:0]    srcAMap,
  output logic [LANES*MAP_W-1:0]    srcBMap
);
  resv_strobe_t strobe;

  resv_ctrl u_ctrl (
    .issueValid(issueValid), .issueSlot(issueSlot), .dstValid(dstValid),
    .commitValid(commitValid), .commitSlot(commitSlot),
    .retireValid(retireValid), .retireSlot(retireSlot),
    .squashMask(squashMask), .strobe(strobe)
  );

  resv_table u_table (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .dstReg(dstReg),
    .srcAReg(srcAReg), .srcBReg(srcBReg), .srcAMap(srcAMap), .srcBMap(srcBMap)
  );
endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk
  import resv_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issueValid,
  input  logic [SLOT_W-1:0]         issueSlot,
  input  logic [LANES-1:0]          dstValid,
  input  logic [LANES*REG_W-1:0]    dstReg,
  input  logic [LANES*REG_W-1:0]    srcAReg,
  input  logic [LANES-1:0]          commitValid,
  input  logic [LANES*SLOT_W-1:0]   commitSlot,
  input  logic                      retireValid,
  input  logic [SLOT_W-1:0]         retireSlot,
  input  logic [MAP_W-1:0]          squashMask,
  input  logic [LANES*MAP_W-1:0]    srcAMap,
  input  logic [LANES*MAP_W-1:0]    srcBMap
);
  logic              lastWrote;
  logic [SLOT_W-1:0] lastSlot;
  logic [REG_W-1:0]  lastDst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastWrote <= 1'b0;
      lastSlot  <= '0;
      lastDst   <= '0;
    end else begin
      lastWrote <= issueValid && dstValid[0];
      lastSlot  <= issueSlot;
      lastDst   <= dstReg[REG_W-1:0];
    end
  end

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issueValid |-> (srcAMap == '0 && srcBMap == '0));

  // R2: lane 0's reservation from last cycle is seen when nothing clears.
  assert_reserve_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lastWrote && issueValid && srcAReg[REG_W-1:0] == lastDst && !retireValid &&
     squashMask == '0 && commitValid == '0) |-> srcAMap[int'(lastSlot)*LANES]);

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    for (genvar j = 0; j < l; j++) begin : g_low
      assert_intra_older_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issueValid && dstValid[j] && dstReg[j*REG_W +: REG_W] == srcAReg[l*REG_W +: REG_W])
        |-> srcAMap[l*MAP_W + int'(issueSlot)*LANES + j]);
    end
    for (genvar c = 0; c < LANES; c++) begin : g_cm
      assert_commit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commitValid[c] && commitSlot[c*SLOT_W +: SLOT_W] != issueSlot)
        |-> (!srcAMap[l*MAP_W + int'(commitSlot[c*SLOT_W +: SLOT_W])*LANES + c] &&
             !srcBMap[l*MAP_W + int'(commitSlot[c*SLOT_W +: SLOT_W])*LANES + c]));
    end
    assert_retire_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (retireValid && retireSlot != issueSlot)
      |-> ((srcAMap[l*MAP_W +: MAP_W] | srcBMap[l*MAP_W +: MAP_W]) & slotBits(retireSlot)) == '0);
    assert_squash_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((srcAMap[l*MAP_W +: MAP_W] | srcBMap[l*MAP_W +: MAP_W]) & squashMask & ~slotBits(issueSlot)) == '0);
  end
endmodule

bind resv_tracker resv_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueSlot(issueSlot),
  .dstValid(dstValid), .dstReg(dstReg), .srcAReg(srcAReg),
  .commitValid(commitValid), .commitSlot(commitSlot),
  .retireValid(retireValid), .retireSlot(retireSlot), .squashMask(squashMask),
  .srcAMap(srcAMap), .srcBMap(srcBMap)
);

// File: tb/tb_resv_tracker.sv
`timescale 1ns/1ps
module tb_resv_tracker;
  localparam int NL = 4;
  localparam int NR = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        issueValid = 1'b0;
  logic [1:0]  issueSlot = '0;
  logic [3:0]  dstValid = '0;
  logic [4:0]  bDst [NL];
  logic [4:0]  bSrcA [NL];
  logic [4:0]  bSrcB [NL];
  logic [3:0]  commitValid = '0;
  logic [1:0]  bCSlot [NL];
  logic        retireValid = 1'b0;
  logic [1:0]  retireSlot = '0;
  logic [15:0] squashMask = '0;
  logic [19:0] dstReg, srcAReg, srcBReg;
  logic [7:0]  commitSlot;
  logic [63:0] srcAMap, srcBMap;

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      dstReg[l*5 +: 5]     = bDst[l];
      srcAReg[l*5 +: 5]    = bSrcA[l];
      srcBReg[l*5 +: 5]    = bSrcB[l];
      commitSlot[l*2 +: 2] = bCSlot[l];
    end
  end

  resv_tracker dut (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueSlot(issueSlot),
    .dstValid(dstValid), .dstReg(dstReg), .srcAReg(srcAReg), .srcBReg(srcBReg),
    .commitValid(commitValid), .commitSlot(commitSlot),
    .retireValid(retireValid), .retireSlot(retireSlot), .squashMask(squashMask),
    .srcAMap(srcAMap), .srcBMap(srcBMap)
  );

  logic [15:0] mdl [NR];
  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  function automatic logic [15:0] pos(input int slot, input int lane);
    return 16'(1) << (slot*4 + lane);
  endfunction

  function automatic logic [15:0] clearBits();
    logic [15:0] m;
    m = squashMask;
    if (retireValid) m |= 16'hF << (int'(retireSlot)*4);
    for (int c = 0; c < NL; c++) if (commitValid[c]) m |= pos(int'(bCSlot[c]), c);
    return m;
  endfunction

  function automatic logic [15:0] expMap(input int lane, input logic [4:0] src);
    logic [15:0] m;
    if (!issueValid) return '0;
    m = mdl[src] & ~clearBits();
    for (int j = 0; j < lane; j++)
      if (dstValid[j] && bDst[j] == src) m |= pos(int'(issueSlot), j);
    return m;
  endfunction

  task automatic clearIn();
    issueValid = 0; dstValid = '0; commitValid = '0; retireValid = 0; squashMask = '0;
    issueSlot = '0; retireSlot = '0;
    for (int l = 0; l < NL; l++) begin bDst[l] = '0; bSrcA[l] = '0; bSrcB[l] = '0; bCSlot[l] = '0; end
  endtask

  // Inputs are set at a falling edge; compare, then let the rising edge update.
  task automatic step(input string tag);
    logic [15:0] nxt [NR];
    logic [15:0] clr;
    logic [15:0] ea, eb;
    #1;
    vectors++;
    for (int l = 0; l < NL; l++) begin
      ea = expMap(l, bSrcA[l]);
      eb = expMap(l, bSrcB[l]);
      if (srcAMap[l*16 +: 16] !== ea) begin
        misses++;
        $display("FAIL %s lane%0d srcA actual=%h expected=%h", tag, l, srcAMap[l*16 +: 16], ea);
      end
      if (srcBMap[l*16 +: 16] !== eb) begin
        misses++;
        $display("FAIL %s lane%0d srcB actual=%h expected=%h", tag, l, srcBMap[l*16 +: 16], eb);
      end
    end
    clr = clearBits();
    for (int r = 0; r < NR; r++) begin
      nxt[r] = mdl[r] & ~clr;
      if (issueValid)
        for (int j = 0; j < NL; j++)
          if (dstValid[j] && int'(bDst[j]) == r) nxt[r] |= pos(int'(issueSlot), j);
    end
    @(posedge clk);
    for (int r = 0; r < NR; r++) mdl[r] = nxt[r];
    @(negedge clk);
  endtask

  // Issue a read-only block reading registers a..a+3 (srcA) and b..b+3 (srcB).
  task automatic readBlock(input int slot, input int a, input int b, input string tag);
    clearIn();
    issueValid = 1; issueSlot = 2'(slot);
    for (int l = 0; l < NL; l++) begin bSrcA[l] = 5'(a + l); bSrcB[l] = 5'(b + l); end
    step(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd24681));
    for (int r = 0; r < NR; r++) mdl[r] = '0;
    clearIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    readBlock(0, 0, 4, "R1");
    readBlock(1, 8, 28, "R1");

    // R2: block in slot 0 reserves r1..r4, block in slot 1 reads them
    clearIn(); issueValid = 1; issueSlot = 0; dstValid = 4'hF;
    for (int l = 0; l < NL; l++) bDst[l] = 5'(1 + l);
    step("R2");
    readBlock(1, 1, 1, "R2");

    // R3: same-block ordering, own and higher lanes excluded
    clearIn(); issueValid = 1; issueSlot = 2; dstValid = 4'b0101;
    bDst[0] = 20; bDst[2] = 20; bDst[1] = 21; bDst[3] = 21;
    for (int l = 0; l < NL; l++) begin bSrcA[l] = 20; bSrcB[l] = 21; end
    step("R3");

    // R10: disabled destination reserves nothing
    clearIn(); issueValid = 1; issueSlot = 3; dstValid = 4'b0000; bDst[0] = 22; bDst[1] = 22;
    bSrcA[2] = 22;
    step("R10");
    readBlock(0, 22, 22, "R10");

    // R4: commit lane1 slot0 (r2 producer) while reading r1..r4
    clearIn(); issueValid = 1; issueSlot = 1; commitValid = 4'b0010; bCSlot[1] = 0;
    for (int l = 0; l < NL; l++) begin bSrcA[l] = 5'(1 + l); bSrcB[l] = 20; end
    step("R4");
    readBlock(2, 1, 1, "R4");

    // R5: retire slot 2 while reading r20
    clearIn(); issueValid = 1; issueSlot = 3; retireValid = 1; retireSlot = 2;
    for (int l = 0; l < NL; l++) begin bSrcA[l] = 20; bSrcB[l] = 21; end
    step("R5");

    // R6: squash lane0 of slot0 (r1)
    clearIn(); issueValid = 1; issueSlot = 1; squashMask = 16'h0001;
    for (int l = 0; l < NL; l++) begin bSrcA[l] = 5'(1 + l); bSrcB[l] = 1; end
    step("R6");
    readBlock(1, 1, 3, "R6");

    // R8: retire slot 0 while slot 0 reissues and writes r9
    clearIn(); issueValid = 1; issueSlot = 0; retireValid = 1; retireSlot = 0;
    dstValid = 4'b0001; bDst[0] = 9;
    step("R8");
    readBlock(1, 9, 3, "R8");

    // R9: idle cycle presenting destinations
    clearIn(); dstValid = 4'hF; for (int l = 0; l < NL; l++) begin bDst[l] = 25; bSrcA[l] = 9; end
    step("R9");
    readBlock(2, 25, 9, "R9");

    // R7: clear everything, then four blocks all writing r3
    clearIn(); squashMask = 16'hFFFF; step("R7");
    for (int s = 0; s < 3; s++) begin
      clearIn(); issueValid = 1; issueSlot = 2'(s); dstValid = 4'hF;
      for (int l = 0; l < NL; l++) bDst[l] = 3;
      step("R7");
    end
    clearIn(); issueValid = 1; issueSlot = 3; dstValid = 4'b0111;
    for (int l = 0; l < 3; l++) bDst[l] = 3;
    for (int l = 0; l < NL; l++) begin bSrcA[l] = 3; bSrcB[l] = 3; end
    step("R7");
    if (mdl[3] !== 16'h7FFF) begin misses++; $display("FAIL R7 model actual=%h expected=7fff", mdl[3]); end

    // Random blocks mixing reservations and clears (R2 R3 R4 R5 R6 R8)
    for (int n = 0; n < 600; n++) begin
      clearIn();
      issueValid = ($urandom % 4) != 0;
      issueSlot  = 2'(n % 4);
      dstValid   = 4'($urandom);
      for (int l = 0; l < NL; l++) begin
        bDst[l]  = 5'($urandom % 8);
        bSrcA[l] = 5'($urandom % 8);
        bSrcB[l] = 5'($urandom % 8);
        bCSlot[l] = 2'($urandom);
      end
      commitValid = 4'($urandom) & 4'($urandom);
      retireValid = ($urandom % 5) == 0;
      retireSlot  = 2'((n + 1) % 4);
      if (($urandom % 10) == 0) squashMask = 16'($urandom);
      step("R2-R8 random");
    end

    summary();
  end
endmodule